// File: doc/BRIEF.md
# Open-Drain GPIO Port Controller

This block controls an 8-bit port whose pins can only sink current. For each pin it produces a drive-low enable that turns on the pad's pull-down transistor. When the enable is off, the pin floats, and an external pull-up makes it read high. Software sets the pins by writing a data register that holds one output latch bit per pin. A plain read of that register returns the pin levels after synchronization. A read flagged as read-modify-write returns the latch itself, so bit-set and bit-clear instructions leave the bits they do not target unchanged.

Each pin is switched on its own between port use and peripheral use through a function-select register. In peripheral use, the peripheral's output bit drives the open-drain pin. The synchronized pin level is always presented on the peripheral input. A per-bit analog-enable register routes a pin to the analog path and forces its digital input to 0. A standby gate turns off every driver and blocks every digital input. The gate applies in hardware standby. It also applies in stop or timebase-timer mode when the pin-level-hold control is set.

Top module: `odport_ctrl`

## Requirements
- R1: After reset, every output latch bit is 1, every analog-enable bit is 1, every function-select bit is 0 (port), no drive-low enable is active and read data is 0.
- R2: A write with address 0 stores write data into the output latch. In port mode, with no standby, a latch bit of 0 asserts that pin's drive-low enable and a latch bit of 1 releases it.
- R3: A read at address 0 without the read-modify-write flag returns the digital input levels, so a released pin pulled low externally reads 0.
- R4: A read at address 0 with the read-modify-write flag returns the output latch contents, even where the pin level differs from the latch.
- R5: Address 1 is the analog-enable register, readable and writable. The register drives the analog route output. A set bit forces that pin's digital input to 0.
- R6: Address 2 is the function-select register, where 1 means peripheral. In peripheral mode the drive-low enable is the inverse of the peripheral output bit. The output latch then has no effect on the pin but stays readable.
- R7: The peripheral input presents the digital input level of every pin.
- R8: The standby gate is hardware standby, or stop or timebase-timer mode combined with the hold control. While the gate applies, all drive-low enables are 0 and all digital inputs read 0. Stop mode without the hold control changes nothing.
- R9: The pin level passes through two flip-flops. A change becomes visible on the digital input after the second clock edge and not after the first.
- R10: Read data is registered. It is valid one cycle after the read strobe and holds until the next strobe. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe |
| rd_rmw | input | 1 | Marks the read as part of a read-modify-write |
| addr | input | 2 | 0 data, 1 analog enable, 2 function select, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_level | input | 8 | Sampled pad levels |
| pin_drive_low | output | 8 | Pad pull-down enables |
| per_out | input | 8 | Peripheral output bits |
| per_in | output | 8 | Peripheral input bits |
| ana_route | output | 8 | Analog path routing enables |
| stop_mode | input | 1 | Stop mode active |
| tbt_mode | input | 1 | Timebase-timer mode active |
| hold_ctl | input | 1 | Pin-level-hold control bit |
| hw_standby | input | 1 | Hardware standby active |

## Verification
The data register is first read while the analog enables are still at their reset value, and then read with them cleared. This shows that the digital input is gated. A checkerboard latch value is read both ways with one released pin held low from outside. The plain read and the read-modify-write read then differ only in that bit, which separates the pin path from the latch path. Half the bits are moved to peripheral use with a mixed peripheral output. This shows that the driver source is selected per bit. Each standby input combination is applied on its own, which separates the active gate conditions from stop mode without the hold control.

// File: rtl/odport_pkg.sv
package odport_pkg;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_ANALOG = 2'd1,
        SEL_FUNC   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    function automatic logic standby_gate(input logic stop_m, input logic tbt_m,
                                          input logic hold, input logic hw_stby);
        return ((stop_m | tbt_m) & hold) | hw_stby;
    endfunction

endpackage

// File: rtl/odport_regs.sv
module odport_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         rd_rmw,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] din,
    output logic [W-1:0] latch,
    output logic [W-1:0] ana_en,
    output logic [W-1:0] fsel,
    output logic [W-1:0] rdata
);
    import odport_pkg::*;

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] ana;
        logic [W-1:0] fsel;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (sel)
                SEL_DATA:   s_d.latch = wdata;
                SEL_ANALOG: s_d.ana   = wdata;
                SEL_FUNC:   s_d.fsel  = wdata;
                default:    ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_DATA:   s_d.rdata = rd_rmw ? s_q.latch : din;
                SEL_ANALOG: s_d.rdata = s_q.ana;
                SEL_FUNC:   s_d.rdata = s_q.fsel;
                default:    s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.latch <= '1;
            s_q.ana   <= '1;
            s_q.fsel  <= '0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign latch  = s_q.latch;
    assign ana_en = s_q.ana;
    assign fsel   = s_q.fsel;
    assign rdata  = s_q.rdata;

    assert_write_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (latch == $past(wdata)));

    assert_rmw_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_rmw && addr == 2'd0) |=> (rdata == $past(latch)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/odport_insync.sv
module odport_insync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_level,
    input  logic [W-1:0] block_mask,
    output logic [W-1:0] din
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_level;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign din = s_q.sync & ~block_mask;

    assert_blocked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((din & block_mask) == '0));

endmodule

// File: rtl/odport_drive.sv
module odport_drive #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic [W-1:0] fsel,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] per_out,
    output logic [W-1:0] drive_low
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic src_d;
        always_comb begin
            src_d        = fsel[i] ? per_out[i] : latch[i];
            drive_low[i] = ~gate & ~src_d;
        end
    end

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (drive_low == '0));

endmodule

// File: rtl/odport_ctrl.sv
module odport_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         rd_rmw,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_level,
    output logic [W-1:0] pin_drive_low,
    input  logic [W-1:0] per_out,
    output logic [W-1:0] per_in,
    output logic [W-1:0] ana_route,
    input  logic         stop_mode,
    input  logic         tbt_mode,
    input  logic         hold_ctl,
    input  logic         hw_standby
);
    import odport_pkg::*;

    logic         gate;
    logic [W-1:0] latch, ana_en, fsel, din, block_mask;

    assign gate       = standby_gate(stop_mode, tbt_mode, hold_ctl, hw_standby);
    assign block_mask = ana_en | {W{gate}};

    odport_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rd_rmw (rd_rmw),
        .addr   (addr),
        .wdata  (wdata),
        .din    (din),
        .latch  (latch),
        .ana_en (ana_en),
        .fsel   (fsel),
        .rdata  (rdata)
    );

    odport_insync #(.W(W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_level  (pin_level),
        .block_mask (block_mask),
        .din        (din)
    );

    odport_drive #(.W(W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .fsel      (fsel),
        .latch     (latch),
        .per_out   (per_out),
        .drive_low (pin_drive_low)
    );

    assign per_in    = din;
    assign ana_route = ana_en;

    assert_gate_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (per_in == '0));

    assert_analog_no_digital_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_route & per_in) == '0));

endmodule

// File: tb/odport_ctrl_tb.sv
module odport_ctrl_tb;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_en = 0, rd_en = 0, rd_rmw = 0;
    logic [1:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pin_level, pin_drive_low, per_in, ana_route;
    logic [W-1:0] per_out = '0;
    logic [W-1:0] ext_low = '0;
    logic         stop_mode = 0, tbt_mode = 0, hold_ctl = 0, hw_standby = 0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    assign pin_level = ~(pin_drive_low | ext_low);

    odport_ctrl #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_rmw(rd_rmw),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_level(pin_level),
        .pin_drive_low(pin_drive_low), .per_out(per_out), .per_in(per_in),
        .ana_route(ana_route), .stop_mode(stop_mode), .tbt_mode(tbt_mode),
        .hold_ctl(hold_ctl), .hw_standby(hw_standby)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic f, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1; addr = a; rd_rmw = f;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0; rd_rmw = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        idle(2);
        rst_n = 1;
        idle(1);
        check("R1 drive after reset", pin_drive_low, 8'h00);
        check("R1 rdata after reset", rdata, 8'h00);
        check("R1 analog route after reset", ana_route, 8'hFF);
        rd(2'd0, 1'b1, 8'hFF, "R1 latch reset");
        rd(2'd1, 1'b0, 8'hFF, "R1 analog reset");
        rd(2'd2, 1'b0, 8'h00, "R1 fsel reset");
        rd(2'd0, 1'b0, 8'h00, "R5 reset analog blocks digital read");

        wr(2'd1, 8'h00);
        idle(2);
        rd(2'd0, 1'b0, 8'hFF, "R3 released pins read high");

        wr(2'd0, 8'hA5);
        check("R2 drive from latch", pin_drive_low, 8'h5A);
        idle(3);
        rd(2'd0, 1'b0, 8'hA5, "R3 pin read");

        ext_low = 8'h01;
        idle(3);
        rd(2'd0, 1'b0, 8'hA4, "R3 external low seen");
        rd(2'd0, 1'b1, 8'hA5, "R4 rmw returns latch");

        ext_low = 8'h81;
        idle(1);
        check("R9 one edge not yet visible", per_in, 8'hA4);
        idle(1);
        check("R9 visible after two edges", per_in, 8'h24);
        check("R7 per_in follows pins", per_in, 8'h24);

        wr(2'd1, 8'h0F);
        check("R5 analog bits force zero", per_in, 8'h20);
        check("R5 analog route", ana_route, 8'h0F);
        rd(2'd1, 1'b0, 8'h0F, "R5 analog readback");

        per_out = 8'h30;
        wr(2'd2, 8'hF0);
        check("R6 peripheral drives upper bits", pin_drive_low, 8'hCA);
        idle(3);
        check("R7 per_in in peripheral mode", per_in, 8'h30);
        rd(2'd2, 1'b0, 8'hF0, "R6 fsel readback");
        rd(2'd0, 1'b1, 8'hA5, "R6 latch kept under peripheral");

        @(negedge clk);
        stop_mode = 1; hold_ctl = 0;
        #1;
        check("R8 stop without hold no effect", pin_drive_low, 8'hCA);
        check("R8 stop without hold input kept", per_in, 8'h30);
        hold_ctl = 1;
        #1;
        check("R8 stop with hold drivers off", pin_drive_low, 8'h00);
        check("R8 stop with hold input blocked", per_in, 8'h00);
        rd(2'd0, 1'b0, 8'h00, "R8 read blocked");
        @(negedge clk);
        stop_mode = 0; hold_ctl = 0; hw_standby = 1;
        #1;
        check("R8 hw standby drivers off", pin_drive_low, 8'h00);
        hw_standby = 0; tbt_mode = 1; hold_ctl = 1;
        #1;
        check("R8 timebase with hold drivers off", pin_drive_low, 8'h00);
        tbt_mode = 0; hold_ctl = 0;
        #1;
        check("R8 release restores drive", pin_drive_low, 8'hCA);
        idle(3);
        check("R8 release restores input", per_in, 8'h30);

        rd(2'd3, 1'b0, 8'h00, "R10 unused address");
        rd(2'd2, 1'b0, 8'hF0, "R10 registered read");
        idle(3);
        check("R10 rdata held", rdata, 8'hF0);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #160000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule